// File: doc/BRIEF.md
# Multiplexed-Bus Burst Flash Read Controller

This block sits on the host side of a NOR-style flash device whose low address half and data share one 16-bit bus. On a user request it asserts chip enable, pulses the address-valid strobe low for one clock while driving the low address word on the shared bus and the upper address bits on dedicated pins, then releases the bus and asserts output enable one clock later. The initial access length comes from a 4-bit latency code sampled with the request: the first data word is on the bus in clock `code + 4`, counting the address-valid clock as clock 1.

From that clock on, the controller captures one word per clock whenever the device's ready input is high and presents it to the user with its flash address. When ready is low, nothing is delivered and the burst address does not advance. A stop request ends the burst on the next edge and returns the controller to idle, where it accepts the next request. The shared bus is shown at the pins as a separate output value, a drive-enable and an input value. The pad-level tri-state buffer sits outside the block.

Top module: `burst_flash_rd`

## Requirements
- R1: After reset `ce_n_o`, `avd_n_o` and `oe_n_o` are 1, and `ad_oe_o` and `rd_valid_o` are 0.
- R2: On the first clock edge where `req_i` is 1 in idle, the block does all of the following for the next clock (clock 1). It drives `ce_n_o` = 0, `avd_n_o` = 0, `ad_oe_o` = 1, `ad_o` = `addr_i[15:0]` and `addr_hi_o` = `addr_i[24:16]`. `avd_n_o` is low for exactly that one clock, and `addr_hi_o` holds its value for the whole burst.
- R3: In clock 2, `avd_n_o` is 1 and `ad_oe_o` is 0. `ad_oe_o` is never 1 while `oe_n_o` is 0.
- R4: `oe_n_o` goes low in clock 3, one clock after `avd_n_o` returns high, and stays low until the burst ends.
- R5: With latency code C, the block captures the first word from `ad_i` at the end of clock C+4. With ready high, `rd_valid_o` is first 1 in clock C+5.
- R6: The k-th delivered word (k = 0, 1, ...) is the word the device returned for address a+k, where a is the 25-bit start address. `rd_addr_o` equals a+k, with the carry propagating into the upper address bits and the sum taken modulo 2^25.
- R7: In any clock from clock C+4 onward where `rdy_i` is 0, `rd_valid_o` is 0 in the following clock and the burst address does not advance.
- R8: When `stop_i` is 1 at an edge during a burst, the block drives `ce_n_o` = 1, `oe_n_o` = 1 and `rd_valid_o` = 0 after that edge, even if `rdy_i` was high, and returns to idle.
- R9: `req_i` and `addr_i` have no effect while a burst is in progress, including at the edge where a stop is taken.
- R10: `rdy_i` is ignored before clock C+4, so an early high ready does not bring the first valid word earlier than clock C+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a burst (taken only in idle) |
| addr_i | input | 25 | Burst start word address |
| lat_code_i | input | 4 | Initial latency code, access = code + 4 clocks |
| stop_i | input | 1 | End the current burst |
| rd_valid_o | output | 1 | Delivered word valid |
| rd_data_o | output | 16 | Delivered word |
| rd_addr_o | output | 25 | Flash address of delivered word |
| ce_n_o | output | 1 | Flash chip enable, active low |
| avd_n_o | output | 1 | Address-valid strobe, active low |
| oe_n_o | output | 1 | Flash output enable, active low |
| addr_hi_o | output | 9 | Upper address bits on dedicated pins |
| ad_o | output | 16 | Shared bus value driven by host |
| ad_oe_o | output | 1 | Host drive enable for shared bus |
| ad_i | input | 16 | Shared bus value from the pad |
| rdy_i | input | 1 | Device ready qualifying data |

## Verification
The assertions check several rules on every cycle. They check the one-clock strobe width and that the strobe only occurs with chip enable. They check that the host drive and output enable never overlap, and that output enable falls exactly one clock after the strobe rises with the bus already released. They also check that a stop closes the burst, that a ready-low stream cycle yields no word, and that consecutive words carry consecutive addresses. Only the bench scenarios show the exact first-data clock for each of the sixteen latency codes and the data content against a device model. They also cover address carry across the 16-bit boundary and the 25-bit wrap, stalls under irregular ready patterns, early ready being ignored, and requests arriving mid-burst or at the stop edge.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_STREAM = 2'd3
  } bfr_state_e;

  localparam int unsigned LAT_OFS = 4;  // access clocks = code + LAT_OFS
  localparam int unsigned OE_CLK  = 3;  // clock index where output enable asserts
endpackage

// File: rtl/bfr_seq.sv
module bfr_seq
  import bfr_pkg::*;
#(
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             stop_i,
  input  logic [LAT_W-1:0] lat_code_i,
  input  logic             rdy_i,
  output logic             start_o,
  output logic             capture_o,
  output logic             stream_o,
  output logic             ce_n_o,
  output logic             avd_n_o,
  output logic             oe_n_o,
  output logic             ad_oe_o
);
  localparam int unsigned CNT_W = $clog2((1 << LAT_W) + LAT_OFS);

  bfr_state_e       state_q;
  logic [CNT_W-1:0] clk_idx_q;  // current clock index within the access
  logic [CNT_W-1:0] lat_q;

  assign start_o   = (state_q == ST_IDLE) && req_i;
  assign stream_o  = (state_q == ST_STREAM);
  assign capture_o = stream_o && rdy_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      clk_idx_q <= '0;
      lat_q     <= '0;
      ce_n_o    <= 1'b1;
      avd_n_o   <= 1'b1;
      oe_n_o    <= 1'b1;
      ad_oe_o   <= 1'b0;
    end else if (state_q != ST_IDLE && stop_i) begin
      state_q <= ST_IDLE;
      ce_n_o  <= 1'b1;
      avd_n_o <= 1'b1;
      oe_n_o  <= 1'b1;
      ad_oe_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            state_q   <= ST_ADDR;
            clk_idx_q <= CNT_W'(1);
            lat_q     <= CNT_W'(lat_code_i) + CNT_W'(LAT_OFS);
            ce_n_o    <= 1'b0;
            avd_n_o   <= 1'b0;
            ad_oe_o   <= 1'b1;
          end
        end
        ST_ADDR: begin
          state_q   <= ST_WAIT;
          clk_idx_q <= clk_idx_q + 1'b1;
          avd_n_o   <= 1'b1;
          ad_oe_o   <= 1'b0;
        end
        ST_WAIT: begin
          clk_idx_q <= clk_idx_q + 1'b1;
          if (clk_idx_q == CNT_W'(OE_CLK - 1)) oe_n_o <= 1'b0;
          if (clk_idx_q == lat_q - 1'b1) state_q <= ST_STREAM;
        end
        ST_STREAM: ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  avd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avd_n_o |=> avd_n_o);
  // R2
  avd_in_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avd_n_o |-> !ce_n_o);
  // R3
  no_bus_fight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ad_oe_o && !oe_n_o));
  // R4
  oe_after_avd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n_o) |-> ($past(avd_n_o) && !$past(ad_oe_o) && !$past(avd_n_o, 2)));
  // R8
  stop_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && stop_i) |=> (ce_n_o && oe_n_o && state_q == ST_IDLE));
endmodule

// File: rtl/bfr_addr_ctr.sv
module bfr_addr_ctr #(
  parameter int unsigned ADDR_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] cur_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      cur_o  <= '0;
    end else if (load_i) begin
      base_o <= addr_i;
      cur_o  <= addr_i;
    end else if (adv_i) begin
      cur_o <= cur_o + 1'b1;
    end
  end
endmodule

// File: rtl/bfr_capture.sv
module bfr_capture #(
  parameter int unsigned ADDR_W = 25,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_addr_o  <= '0;
    end else begin
      rd_valid_o <= capture_i;
      if (capture_i) begin
        rd_data_o <= ad_i;
        rd_addr_o <= cur_addr_i;
      end
    end
  end

  // R6
  seq_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_valid_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));
endmodule

// File: rtl/burst_flash_rd.sv
module burst_flash_rd #(
  parameter int unsigned ADDR_W = 25,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LAT_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [LAT_W-1:0]         lat_code_i,
  input  logic                     stop_i,
  output logic                     rd_valid_o,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     ce_n_o,
  output logic                     avd_n_o,
  output logic                     oe_n_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  input  logic [DATA_W-1:0]        ad_i,
  input  logic                     rdy_i
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic              start, capture, stream;
  logic [ADDR_W-1:0] base_addr, cur_addr;

  bfr_seq #(.LAT_W(LAT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .stop_i     (stop_i),
    .lat_code_i (lat_code_i),
    .rdy_i      (rdy_i),
    .start_o    (start),
    .capture_o  (capture),
    .stream_o   (stream),
    .ce_n_o     (ce_n_o),
    .avd_n_o    (avd_n_o),
    .oe_n_o     (oe_n_o),
    .ad_oe_o    (ad_oe_o)
  );

  bfr_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .adv_i  (capture),
    .addr_i (addr_i),
    .base_o (base_addr),
    .cur_o  (cur_addr)
  );

  bfr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .ad_i       (ad_i),
    .cur_addr_i (cur_addr),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .rd_addr_o  (rd_addr_o)
  );

  assign ad_o      = base_addr[DATA_W-1:0];
  assign addr_hi_o = base_addr[ADDR_W-1 -: HI_W];

  // R7
  stall_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stream && !rdy_i) |=> !rd_valid_o);
  // R2
  hi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_o && !avd_n_o) |=> (ce_n_o || $stable(addr_hi_o)));
endmodule

// File: tb/tb_burst_flash_rd.sv
`timescale 1ns/1ps
module tb_burst_flash_rd;
  localparam int AW = 25;
  localparam int DW = 16;
  localparam int LW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, req, stop, rdy;
  logic [AW-1:0] addr;
  logic [LW-1:0] code;
  logic          rd_valid, ce_n, avd_n, oe_n, ad_oe;
  logic [DW-1:0] rd_data, ad_out, ad_in;
  logic [AW-1:0] rd_addr;
  logic [AW-DW-1:0] addr_hi;

  burst_flash_rd dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .lat_code_i(code),
    .stop_i(stop), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_addr_o(rd_addr),
    .ce_n_o(ce_n), .avd_n_o(avd_n), .oe_n_o(oe_n), .addr_hi_o(addr_hi),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .rdy_i(rdy)
  );

  int tests = 0;
  int fails = 0;

  function automatic logic [DW-1:0] fword(logic [AW-1:0] a);
    return a[15:0] ^ {a[24:16], 7'h35} ^ 16'h9C6B;
  endfunction

  // device model
  logic [AW-1:0] maddr = '0;
  int mclk = 0;
  int widx = 0;
  int mlat = 4;
  int rdy_mode = 0;

  always @(posedge clk) begin
    if (!ce_n) begin
      if (!avd_n) begin
        maddr <= {addr_hi, ad_out};
        mclk  <= 2;
        widx  <= 0;
      end else begin
        mclk <= mclk + 1;
        if (mclk >= mlat && rdy) widx <= widx + 1;
      end
    end else mclk <= 0;
  end

  always_comb begin
    if (ce_n || mclk == 0) rdy = 1'b0;
    else case (rdy_mode)
      1:       rdy = (mclk >= mlat) && (mclk % 3 != 1);
      2:       rdy = 1'b1;
      default: rdy = (mclk >= mlat);
    endcase
  end

  assign ad_in = (!oe_n && mclk >= mlat) ? fword(maddr + AW'(widx)) : 16'hDEAD;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_burst(input logic [AW-1:0] a, input logic [LW-1:0] c,
                           input int mode, input int ncyc, input bit midreq);
    int lat;
    int nexp;
    bit prev_rdy;
    bit bad_v;
    bit bad_d;
    bit bad_h;
    lat = int'(c) + 4;
    mlat = lat;
    rdy_mode = mode;
    nexp = 0;
    bad_v = 0; bad_d = 0; bad_h = 0;
    @(negedge clk);
    req = 1'b1; addr = a; code = c;
    @(negedge clk);
    req = 1'b0; addr = ~a; code = ~c;
    // clock 1
    chk(!ce_n && !avd_n && ad_oe, "R2", "strobe phase ce/avd/oe",
        {29'd0, ce_n, avd_n, ad_oe}, 32'd1);
    chk(ad_out == a[15:0] && addr_hi == a[24:16], "R2", "address on pins",
        {7'd0, addr_hi, ad_out}, {7'd0, a});
    prev_rdy = rdy;
    for (int k = 2; k <= ncyc; k++) begin
      @(negedge clk);
      req = 1'b0;
      if (k == 2) begin
        chk(avd_n && !ad_oe && oe_n, "R3", "turnaround clock 2",
            {29'd0, avd_n, ad_oe, oe_n}, 32'd5);
      end
      if (k == 3) chk(!oe_n, "R4", "oe low in clock 3", {31'd0, oe_n}, 32'd0);
      if (k > 3 && oe_n) bad_h = 1;
      if (addr_hi != a[24:16]) bad_h = 1;
      if (rd_valid != ((k - 1 >= lat) && prev_rdy)) begin
        bad_v = 1;
        chk(0, mode == 2 ? "R10" : (mode == 1 ? "R7" : "R5"), "valid timing",
            {31'd0, rd_valid}, {31'd0, (k - 1 >= lat) && prev_rdy});
      end
      if (rd_valid) begin
        if (rd_data != fword(a + AW'(nexp)) || rd_addr != a + AW'(nexp)) begin
          bad_d = 1;
          chk(0, "R6", "word order", {7'd0, rd_addr}, {7'd0, a + AW'(nexp)});
        end
        nexp++;
      end
      if (midreq && k == lat + 2) begin
        req = 1'b1; addr = a + 25'h123; code = 4'd0;
      end
      prev_rdy = rdy;
    end
    if (!bad_v) chk(1, "R5", "valid timing over burst", 0, 0);
    if (!bad_d) chk(nexp > 0, "R6", "words delivered", nexp, 1);
    chk(!bad_h, "R2", "hi address and oe held", {31'd0, bad_h}, 32'd0);
    stop = 1'b1; req = 1'b1; addr = a + 25'h777;
    @(negedge clk);
    stop = 1'b0; req = 1'b0;
    chk(ce_n && oe_n && !rd_valid, "R8", "stop closes burst",
        {29'd0, ce_n, oe_n, rd_valid}, 32'd6);
    @(negedge clk);
    chk(ce_n && avd_n, "R9", "request at stop edge ignored",
        {30'd0, ce_n, avd_n}, 32'd3);
  endtask

  bit done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; stop = 1'b0; addr = '0; code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && avd_n && oe_n && !ad_oe && !rd_valid, "R1", "reset state",
        {27'd0, ce_n, avd_n, oe_n, ad_oe, rd_valid}, 32'h1C);
    // full latency sweep with ready patterns and mid-burst requests
    for (int c = 0; c < 16; c++) begin
      run_burst(25'h0A5_0000 + AW'(c * 97), LW'(c), c % 3, c + 4 + 14, c[0]);
    end
    // carry into upper pins region and 25-bit wrap
    run_burst(25'h000_FFFC, 4'd9, 0, 24, 1'b0);
    run_burst(25'h1FF_FFFD, 4'd7, 1, 26, 1'b1);
    run_burst(25'h0FF_FFFF, 4'd0, 2, 14, 1'b0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule